// File: doc/BRIEF.md
# AHB Slave-Slot Decoder with Boot Remap

This block sits between the granted AHB master and a set of slave slots. It looks at the top four bits of the granted master's address, which give one 256-megabyte window per slot. From them it drives exactly one select line, combinationally, during the address phase. A run-time remap input exchanges slots 0 and 1. A system can then boot from nonvolatile memory placed at address zero and later move RAM into that window. When remap is held low, or left tied low, no swap takes place.

The block also handles the return path. On each rising clock edge where the bus ready is high, it registers which slot was addressed. During the data phase it routes that slot's read data, ready and response back to the masters. A ready copy goes back out to the slaves. A slot number at or above the configured slot count is unmapped. It selects nothing, and its data phase completes at once with OKAY and zero data.

Top module: `ahb_slot_decoder`

## Requirements
- R1: The slot field is address bits [31:28], presented on `haddr_hi`. With remap low, a mapped field value k drives `hsel[k]` high in the same cycle, with no clock delay.
- R2: With remap high, field value 0 selects slot 1 and field value 1 selects slot 0.
- R3: With remap high, every field value of 2 or more selects the same slot as with remap low.
- R4: At most one `hsel` bit is high in any cycle. A field value at or above NSLOT drives all `hsel` bits low.
- R5: The slot shown on the return path is the one addressed at the last rising edge where `hready` was high. It is held while `hready` is low.
- R6: A change of remap during a data phase does not change which slot feeds the return path for that transfer.
- R7: During reset and up to the first capture, `hready` is 1, `hresp` is OKAY (00) and `hrdata` is 0.
- R8: The data phase of an unmapped access returns `hready` 1, OKAY (00) and `hrdata` 0.
- R9: `hready_slv` always equals `hready`.
- R10: The selected slot's 2-bit response passes through unchanged for all four codes: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| remap | input | 1 | Exchange slots 0 and 1 when high |
| haddr_hi | input | SW | Address bits [31:28] of the granted master |
| hsel | output | NSLOT | One-hot slot select, address phase |
| slv_rdata | input | NSLOT*DW | Read data of every slot, slot k at bits [k*DW +: DW] |
| slv_ready | input | NSLOT | Ready of every slot |
| slv_resp | input | 2*NSLOT | Response of every slot, slot k at bits [2k +: 2] |
| hrdata | output | DW | Read data to the masters |
| hready | output | 1 | Ready to the masters |
| hresp | output | 2 | Response to the masters |
| hready_slv | output | 1 | Ready copy fed back to the slaves |

## Verification
The bench builds the design with 12 slots, so field values 12 to 15 are unmapped. It checks that these select nothing and complete with OKAY. A design that ignored the slot count would assert a nonexistent select or return garbage data. Remap is toggled during stalled data phases. A design that routed the return path from the live decode would switch slaves halfway through a transfer. Random slave stalls test whether the captured slot holds while ready is low. A design that captured on every edge would lose the stalled transfer. Slots 0 and 1 are driven under both remap values, which catches a swap applied to the wrong slots or one that leaks into the other slots.

// File: rtl/ahb_slot_decoder.sv
module ahb_slot_decoder #(
  parameter int SW    = 4,
  parameter int NSLOT = 16,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                remap,
  input  logic [SW-1:0]       haddr_hi,
  output logic [NSLOT-1:0]    hsel,
  input  logic [NSLOT*DW-1:0] slv_rdata,
  input  logic [NSLOT-1:0]    slv_ready,
  input  logic [2*NSLOT-1:0]  slv_resp,
  output logic [DW-1:0]       hrdata,
  output logic                hready,
  output logic [1:0]          hresp,
  output logic                hready_slv
);
  localparam logic [SW:0] SLOT_LIM = (SW+1)'(NSLOT);

  logic [SW-1:0] eff;
  logic          mapped;
  logic [SW-1:0] sel_q;
  logic          valid_q;
  logic [DW-1:0] rd_arr [NSLOT];
  logic [1:0]    rsp_arr [NSLOT];

  assign eff    = (remap && haddr_hi[SW-1:1] == '0) ? {haddr_hi[SW-1:1], ~haddr_hi[0]} : haddr_hi;
  assign mapped = {1'b0, eff} < SLOT_LIM;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign hsel[g]    = (eff == SW'(g));
    assign rd_arr[g]  = slv_rdata[g*DW +: DW];
    assign rsp_arr[g] = slv_resp[2*g +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      valid_q <= 1'b0;
    end else if (hready) begin
      sel_q   <= eff;
      valid_q <= mapped;
    end
  end

  assign hready     = valid_q ? slv_ready[sel_q] : 1'b1;
  assign hresp      = valid_q ? rsp_arr[sel_q]   : 2'b00;
  assign hrdata     = valid_q ? rd_arr[sel_q]    : '0;
  assign hready_slv = hready;
endmodule

// File: rtl/ahb_slot_decoder_chk.sv
module ahb_slot_decoder_chk #(
  parameter int SW    = 4,
  parameter int NSLOT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             remap,
  input logic [SW-1:0]    haddr_hi,
  input logic [NSLOT-1:0] hsel,
  input logic             hready,
  input logic [1:0]       hresp,
  input logic             hready_slv
);
  localparam int LIM = NSLOT;

  AST_SEL_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hsel)); // R4
  AST_UNMAPPED_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(haddr_hi) >= LIM) |-> (hsel == '0)); // R4
  AST_SWAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (remap && haddr_hi == SW'(0)) |-> hsel[1]); // R2
  AST_SWAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (remap && haddr_hi == SW'(1)) |-> hsel[0]); // R2
  AST_UNMAPPED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && int'(haddr_hi) >= LIM) |=> (hready && hresp == 2'b00)); // R8
  AST_READY_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    hready_slv == hready); // R9
endmodule

bind ahb_slot_decoder ahb_slot_decoder_chk #(.SW(SW), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .remap(remap), .haddr_hi(haddr_hi), .hsel(hsel),
  .hready(hready), .hresp(hresp), .hready_slv(hready_slv)
);

// File: tb/sim_ahb_slot_decoder.sv
module sim_ahb_slot_decoder;
  localparam int SW = 4;
  localparam int NS = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic remap = 1'b0;
  logic [SW-1:0] haddr_hi = '0;
  logic [NS-1:0] hsel;
  logic [NS*DW-1:0] slv_rdata = '0;
  logic [NS-1:0] slv_ready = '1;
  logic [2*NS-1:0] slv_resp = '0;
  logic [DW-1:0] hrdata;
  logic hready, hready_slv;
  logic [1:0] hresp;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  // reference state
  bit m_valid = 0;
  int m_idx = 0;
  bit m_remap_at_cap = 0;
  bit m_hready = 1;
  int m_eff = 0;
  bit m_started = 0;
  bit [DW-1:0] sd [NS];
  bit [1:0] sr [NS];
  bit sy [NS];

  ahb_slot_decoder #(.SW(SW), .NSLOT(NS), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .remap(remap), .haddr_hi(haddr_hi), .hsel(hsel),
    .slv_rdata(slv_rdata), .slv_ready(slv_ready), .slv_resp(slv_resp),
    .hrdata(hrdata), .hready(hready), .hresp(hresp), .hready_slv(hready_slv)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  function automatic int eff_of(input int f, input bit rm);
    if (rm && f == 0) return 1;
    if (rm && f == 1) return 0;
    return f;
  endfunction

  task automatic drive(input int f, input bit rm, input int rdy_pct);
    haddr_hi = SW'(f);
    remap = rm;
    for (int k = 0; k < NS; k++) begin
      sd[k] = $urandom;
      sr[k] = 2'($urandom);
      sy[k] = ($urandom % 100) < rdy_pct;
      slv_rdata[k*DW +: DW] = sd[k];
      slv_resp[2*k +: 2] = sr[k];
      slv_ready[k] = sy[k];
    end
  endtask

  task automatic compare();
    logic [NS-1:0] e_sel;
    bit e_rdy;
    logic [1:0] e_rsp;
    logic [DW-1:0] e_dat;
    string st, rt;
    int f;
    f = int'(haddr_hi);
    m_eff = eff_of(f, remap);
    e_sel = '0;
    if (m_eff < NS) e_sel[m_eff] = 1'b1;
    if (f >= NS) st = "R4";
    else if (remap && f < 2) st = "R2";
    else if (remap) st = "R3";
    else st = "R1";
    chk(hsel == e_sel, st, DW'(hsel), DW'(e_sel));
    if (m_valid) begin
      e_rdy = sy[m_idx]; e_rsp = sr[m_idx]; e_dat = sd[m_idx];
      rt = (remap != m_remap_at_cap) ? "R6" : "R5";
    end else begin
      e_rdy = 1; e_rsp = 2'b00; e_dat = '0;
      rt = m_started ? "R8" : "R7";
    end
    chk(hready == e_rdy, rt, DW'(hready), DW'(e_rdy));
    chk(hresp == e_rsp, "R10", DW'(hresp), DW'(e_rsp));
    chk(hrdata == e_dat, rt, hrdata, e_dat);
    chk(hready_slv == hready, "R9", DW'(hready_slv), DW'(hready));
    m_hready = e_rdy;
  endtask

  // one bus cycle: update model at edge, drive, then compare away from edge
  task automatic step(input int f, input bit rm, input int rdy_pct);
    @(posedge clk);
    cycles++;
    if (rst_n && m_hready) begin
      m_started = 1;
      m_valid = (m_eff < NS);
      m_idx = m_eff;
      m_remap_at_cap = remap;
    end
    #1 drive(f, rm, rdy_pct);
    #4 compare();
  endtask

  initial begin
    for (int k = 0; k < NS; k++) begin sd[k] = '0; sr[k] = '0; sy[k] = 1; end
    // R7: reset state
    for (int c = 0; c < 3; c++) step(c, 0, 100);
    rst_n = 1'b1;
    // R1: every field value, remap low, slaves always ready
    for (int f = 0; f < 16; f++) step(f, 0, 100);
    // R2 / R3: same with remap high
    for (int f = 0; f < 16; f++) step(f, 1, 100);
    // R8: unmapped back to back
    for (int f = NS; f < 16; f++) step(f, 0, 50);
    // R6: address slot 0, then toggle remap while slots stall
    step(0, 0, 100);
    for (int c = 0; c < 6; c++) step(c % 2, c % 2 == 0, 0);
    step(1, 1, 100);
    // R5 / R10: random traffic with stalls and remap toggles
    for (int c = 0; c < 3000; c++) step(int'($urandom % 16), ($urandom % 4) == 0, 60);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule